// File: doc/BRIEF.md
# Physical-Address Range Invalidation Engine

This block removes granule-protection entries from a small local entry cache when software asks for a physical-address range to be invalidated. A request is one 64-bit operand plus the privilege level of the issuer. The engine decodes the operand against two configuration inputs, the protection granule size and the implemented physical-address width. The decode gives an effective base address and an effective range length. The engine then walks the cache one entry per clock and clears every valid entry whose address falls inside the range. When the walk ends, it raises a one-cycle completion pulse.

Some requests are malformed or depend on a bad configuration: an unknown length code, an unknown granule code, a base that is not aligned to the effective length, or a base beyond the implemented address width. These requests complete at once as silent no-ops, and the cache is left unchanged. A request from any privilege level below 3 is flagged as an undefined access and touches nothing. The cache has a simple write port for loading entries and an exact-match lookup port. Writes are held off while a walk is running.

Top module: `pa_range_inval`

## Requirements
- R1: Operand bits [63:48] have no effect. The length code is read from bits [47:44], the address extension from bits [43:40] and the address from bits [39:0].
- R2: Length codes 0 to 9 select a range of 2^12, 2^14, 2^16, 2^21, 2^25, 2^29, 2^30, 2^34, 2^36 and 2^39 bytes. The range covers addresses at or above the base and below base plus length.
- R3: A length code from 10 to 15 completes with `noop_o` high and clears nothing.
- R4: Granule code 0 selects 4KB, code 1 selects 64KB and code 2 selects 16KB. Granule code 3 completes with `noop_o` high and clears nothing.
- R5: The base address is operand bits [39:0] shifted left by 12, with the bits below the granule size forced to zero.
- R6: A length smaller than the granule is raised to the granule size.
- R7: A base that is not aligned to the effective length completes with `noop_o` high and clears nothing.
- R8: PA-width codes 0 to 7 give 32, 36, 40, 42, 44, 48, 52 and 56 address bits, and any other code gives 48. A base at or above 2^width completes with `noop_o` high and clears nothing.
- R9: Operand bits [43:40] become base bits [55:52] only when the PA-width code is 7. For any other code they are ignored.
- R10: A request with `req_el_i` of 0, 1 or 2 gives `done_o` and `undef_o` one cycle after acceptance, and clears nothing.
- R11: A valid level-3 request walks all `N_ENTRIES` entries. `done_o` rises exactly `N_ENTRIES` cycles after acceptance, and `req_ready_o` is low until then. A no-op request gives `done_o` one cycle after acceptance.
- R12: A write offered during a walk is stalled (`fill_ready_o` low) until the walk is done, so it is never cleared by that walk.
- R13: `lkup_hit_o` is high when a valid entry holds the same 4KB page address as `lkup_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Invalidate request valid |
| req_ready_o | output | 1 | Engine idle, can accept a request |
| req_op_i | input | 64 | Range operand |
| req_el_i | input | 2 | Issuing privilege level |
| gran_sel_i | input | 2 | Protection granule size code |
| pa_width_i | input | 4 | Implemented physical-address width code |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Completed request was an undefined access (valid with done) |
| noop_o | output | 1 | Completed request invalidated nothing because of a fault (valid with done) |
| fill_valid_i | input | 1 | Entry write valid |
| fill_ready_o | output | 1 | Entry write accepted |
| fill_idx_i | input | IDX_W | Entry slot to write |
| fill_addr_i | input | 56 | Physical address of the entry (bits [55:12] kept) |
| lkup_addr_i | input | 56 | Physical address to look up |
| lkup_hit_o | output | 1 | A valid entry matches the looked-up page |

## Verification
Assertions check the handshake behaviour on every cycle. They cover the immediate undefined and no-op completions for bad levels, reserved length codes and the reserved granule code. They also check that the flags appear only with `done_o`, that a full completion always follows a busy period, and that writes are stalled while the engine is busy. Which entries a walk actually clears depends on the decoded base, the effective length, alignment, the address-width limit and the extension bits. Only the bench scenarios show this: they load entries around the range edges and then read each one back through the lookup port.

// File: rtl/pri_pkg.sv
package pri_pkg;
  localparam int PA_W    = 56;
  localparam int PAGE_LG = 12;
  localparam int TAG_W   = PA_W - PAGE_LG;
  localparam int LG_W    = 6;

  typedef enum logic [0:0] {ST_IDLE, ST_WALK} walk_st_t;
endpackage

// File: rtl/pri_decode.sv
module pri_decode
  import pri_pkg::*;
(
  input  logic [63:0]     op_i,
  input  logic [1:0]      gran_sel_i,
  input  logic [3:0]      pa_width_i,
  output logic            bad_o,
  output logic [PA_W-1:0] base_o,
  output logic [PA_W:0]   limit_o
);
  logic [LG_W-1:0] gran_lg, size_lg, eff_lg, pa_bits;
  logic            gran_bad, size_bad, misal, above;
  logic [3:0]      ext;
  logic [PA_W-1:0] raw;
  logic            unused_hi;

  assign unused_hi = ^op_i[63:48];

  always_comb begin
    gran_bad = 1'b0;
    unique case (gran_sel_i)
      2'd0:    gran_lg = 6'd12;
      2'd2:    gran_lg = 6'd14;
      2'd1:    gran_lg = 6'd16;
      default: begin gran_lg = 6'd12; gran_bad = 1'b1; end
    endcase
  end

  always_comb begin
    size_bad = 1'b0;
    unique case (op_i[47:44])
      4'd0:    size_lg = 6'd12;
      4'd1:    size_lg = 6'd14;
      4'd2:    size_lg = 6'd16;
      4'd3:    size_lg = 6'd21;
      4'd4:    size_lg = 6'd25;
      4'd5:    size_lg = 6'd29;
      4'd6:    size_lg = 6'd30;
      4'd7:    size_lg = 6'd34;
      4'd8:    size_lg = 6'd36;
      4'd9:    size_lg = 6'd39;
      default: begin size_lg = 6'd12; size_bad = 1'b1; end
    endcase
  end

  always_comb begin
    unique case (pa_width_i)
      4'd0:    pa_bits = 6'd32;
      4'd1:    pa_bits = 6'd36;
      4'd2:    pa_bits = 6'd40;
      4'd3:    pa_bits = 6'd42;
      4'd4:    pa_bits = 6'd44;
      4'd6:    pa_bits = 6'd52;
      4'd7:    pa_bits = 6'd56;
      default: pa_bits = 6'd48;
    endcase
  end

  assign eff_lg = (size_lg > gran_lg) ? size_lg : gran_lg;
  assign ext    = (pa_width_i == 4'd7) ? op_i[43:40] : 4'd0;
  assign raw    = {ext, op_i[39:0], {PAGE_LG{1'b0}}};
  assign base_o = raw & ~((PA_W'(1) << gran_lg) - PA_W'(1));
  assign misal  = |(base_o & ((PA_W'(1) << eff_lg) - PA_W'(1)));
  assign above  = (pa_bits < LG_W'(PA_W)) && |(base_o >> pa_bits);
  assign limit_o = {1'b0, base_o} + ((PA_W+1)'(1) << eff_lg);
  assign bad_o   = gran_bad | size_bad | misal | above;
endmodule

// File: rtl/pri_entry_store.sv
module pri_entry_store
  import pri_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o
);
  logic [N_ENTRIES-1:0] vld_q, hit_vec;
  logic [TAG_W-1:0]     tag_q [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag_i;
      end else if (clr_en_i && clr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag_i);
  end

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign lk_hit_o   = |hit_vec;
endmodule

// File: rtl/pri_walker.sv
module pri_walker
  import pri_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_el_i,
  input  logic             dec_bad_i,
  input  logic [PA_W-1:0]  dec_base_i,
  input  logic [PA_W:0]    dec_limit_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             rd_valid_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             clr_en_o,
  output logic             done_o,
  output logic             undef_o,
  output logic             noop_o
);
  walk_st_t         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W:0]    limit_q;
  logic             done_q, undef_q, noop_q;
  logic [PA_W-1:0]  ent_addr;
  logic             accept, last;

  assign accept   = req_valid_i && (st_q == ST_IDLE);
  assign last     = (idx_q == IDX_W'(N_ENTRIES - 1));
  assign ent_addr = {rd_tag_i, {PAGE_LG{1'b0}}};
  assign clr_en_o = (st_q == ST_WALK) && rd_valid_i &&
                    (ent_addr >= base_q) && ({1'b0, ent_addr} < limit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      noop_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      noop_q  <= 1'b0;
      if (accept) begin
        if (req_el_i != 2'd3) begin
          done_q  <= 1'b1;
          undef_q <= 1'b1;
        end else if (dec_bad_i) begin
          done_q <= 1'b1;
          noop_q <= 1'b1;
        end else begin
          st_q    <= ST_WALK;
          idx_q   <= '0;
          base_q  <= dec_base_i;
          limit_q <= dec_limit_i;
        end
      end else if (st_q == ST_WALK) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rd_idx_o    = idx_q;
  assign done_o      = done_q;
  assign undef_o     = undef_q;
  assign noop_o      = noop_q;
endmodule

// File: rtl/pa_range_inval.sv
module pa_range_inval
  import pri_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [63:0]      req_op_i,
  input  logic [1:0]       req_el_i,
  input  logic [1:0]       gran_sel_i,
  input  logic [3:0]       pa_width_i,
  output logic             done_o,
  output logic             undef_o,
  output logic             noop_o,
  input  logic             fill_valid_i,
  output logic             fill_ready_o,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [PA_W-1:0]  fill_addr_i,
  input  logic [PA_W-1:0]  lkup_addr_i,
  output logic             lkup_hit_o
);
  logic             dec_bad, rd_valid, clr_en;
  logic [PA_W-1:0]  dec_base;
  logic [PA_W:0]    dec_limit;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic             unused_lo;

  assign unused_lo = ^{fill_addr_i[PAGE_LG-1:0], lkup_addr_i[PAGE_LG-1:0]};

  pri_decode u_dec (
    .op_i       (req_op_i),
    .gran_sel_i (gran_sel_i),
    .pa_width_i (pa_width_i),
    .bad_o      (dec_bad),
    .base_o     (dec_base),
    .limit_o    (dec_limit)
  );

  pri_walker #(.N_ENTRIES(N_ENTRIES)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_el_i    (req_el_i),
    .dec_bad_i   (dec_bad),
    .dec_base_i  (dec_base),
    .dec_limit_i (dec_limit),
    .rd_idx_o    (rd_idx),
    .rd_valid_i  (rd_valid),
    .rd_tag_i    (rd_tag),
    .clr_en_o    (clr_en),
    .done_o      (done_o),
    .undef_o     (undef_o),
    .noop_o      (noop_o)
  );

  // writes share the idle window with requests: none can land mid-walk
  assign fill_ready_o = req_ready_o;

  pri_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (fill_valid_i && fill_ready_o),
    .wr_idx_i   (fill_idx_i),
    .wr_tag_i   (fill_addr_i[PA_W-1:PAGE_LG]),
    .clr_en_i   (clr_en),
    .clr_idx_i  (rd_idx),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .lk_tag_i   (lkup_addr_i[PA_W-1:PAGE_LG]),
    .lk_hit_o   (lkup_hit_o)
  );
endmodule

// File: rtl/pri_checker.sv
module pri_checker
  import pri_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [63:0]      req_op_i,
  input logic [1:0]       req_el_i,
  input logic [1:0]       gran_sel_i,
  input logic             done_o,
  input logic             undef_o,
  input logic             noop_o,
  input logic             fill_valid_i,
  input logic             fill_ready_o,
  input logic [IDX_W-1:0] fill_idx_i
);
  AST_UNDEF_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_el_i != 2'd3) |=> (done_o && undef_o && !noop_o)); // R10
  AST_RSVD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_el_i == 2'd3 && req_op_i[47:44] >= 4'd10) |=> (done_o && noop_o)); // R3
  AST_RSVD_GRAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_el_i == 2'd3 && gran_sel_i == 2'd3) |=> (done_o && noop_o)); // R4
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || noop_o) |-> (done_o && !(undef_o && noop_o))); // R11
  AST_WALK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !undef_o && !noop_o) |-> $past(!req_ready_o)); // R11
  AST_FILL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !req_ready_o) |-> !fill_ready_o); // R12
  AST_FILL_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> (int'(fill_idx_i) < N_ENTRIES)); // R12
endmodule

bind pa_range_inval pri_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (.*);

// File: tb/tb_pa_range_inval.sv
module tb_pa_range_inval;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_op = '0;
  logic [1:0]  req_el = 2'd3, gran = 2'd0;
  logic [3:0]  paw = 4'd5;
  logic        done, undef, noop;
  logic        fill_valid = 1'b0, fill_ready;
  logic [IW-1:0] fill_idx = '0;
  logic [55:0] fill_addr = '0, lkup_addr = '0;
  logic        lkup_hit;

  int vec = 0, miss = 0;
  logic [55:0] m_addr [N];
  logic        m_vld  [N];

  always #2 clk = ~clk;

  pa_range_inval #(.N_ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_el_i(req_el), .gran_sel_i(gran), .pa_width_i(paw),
    .done_o(done), .undef_o(undef), .noop_o(noop), .fill_valid_i(fill_valid),
    .fill_ready_o(fill_ready), .fill_idx_i(fill_idx), .fill_addr_i(fill_addr),
    .lkup_addr_i(lkup_addr), .lkup_hit_o(lkup_hit));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // status: 0 walk, 1 undefined, 2 no-op
  function automatic int ref_decode(input logic [63:0] op, input logic [1:0] el,
      input logic [1:0] g, input logic [3:0] pc,
      output logic [63:0] base, output logic [63:0] len);
    logic [63:0] gb, sb, lim;
    int wbits;
    bit bad = 0;
    case (g)
      2'd0: gb = 64'h1000;
      2'd2: gb = 64'h4000;
      2'd1: gb = 64'h10000;
      default: begin gb = 64'h1000; bad = 1; end
    endcase
    case (op[47:44])
      4'd0: sb = 64'd1 << 12;  4'd1: sb = 64'd1 << 14;
      4'd2: sb = 64'd1 << 16;  4'd3: sb = 64'd1 << 21;
      4'd4: sb = 64'd1 << 25;  4'd5: sb = 64'd1 << 29;
      4'd6: sb = 64'd1 << 30;  4'd7: sb = 64'd1 << 34;
      4'd8: sb = 64'd1 << 36;  4'd9: sb = 64'd1 << 39;
      default: begin sb = 64'h1000; bad = 1; end
    endcase
    case (pc)
      4'd0: wbits = 32; 4'd1: wbits = 36; 4'd2: wbits = 40; 4'd3: wbits = 42;
      4'd4: wbits = 44; 4'd6: wbits = 52; 4'd7: wbits = 56;
      default: wbits = 48;
    endcase
    len  = (sb < gb) ? gb : sb;
    base = {20'd0, op[39:0]} * 64'h1000;
    if (pc == 4'd7) base = base + ({60'd0, op[43:40]} << 52);
    base = base - (base % gb);
    lim  = 64'd1 << wbits;
    if (base % len != 0) bad = 1;
    if (base >= lim) bad = 1;
    if (el != 2'd3) return 1;
    if (bad) return 2;
    return 0;
  endfunction

  task automatic do_fill(input int idx, input logic [55:0] a);
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = IW'(idx); fill_addr = a;
    while (!fill_ready) @(negedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    m_vld[idx] = 1'b1; m_addr[idx] = {a[55:12], 12'd0};
  endtask

  task automatic check_all(input string rq);
    for (int i = 0; i < N; i++) begin
      bit e = 0;
      for (int j = 0; j < N; j++) if (m_vld[j] && m_addr[j] == m_addr[i]) e = 1;
      lkup_addr = m_addr[i];
      #1;
      chk(lkup_hit == e, rq, {63'd0, lkup_hit}, {63'd0, e});
    end
  endtask

  task automatic do_req(input logic [63:0] op, input logic [1:0] el, input string rq);
    logic [63:0] b, l;
    int st, lat;
    st = ref_decode(op, el, gran, paw, b, l);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_el = el;
    @(negedge clk);
    req_valid = 1'b0;
    if (st == 0) chk(!req_ready, {rq, " R11 busy"}, {63'd0, req_ready}, 64'd0);
    lat = 0;
    while (!done && lat < 4 * N) begin @(negedge clk); lat++; end
    chk(lat == ((st == 0) ? N : 0), {rq, " R11 latency"}, 64'(lat), 64'((st == 0) ? N : 0));
    chk(undef == (st == 1), {rq, " R10 undef"}, {63'd0, undef}, {63'd0, st == 1});
    chk(noop == (st == 2), {rq, " R3/R7/R8 noop"}, {63'd0, noop}, {63'd0, st == 2});
    if (st == 0)
      for (int i = 0; i < N; i++)
        if ({8'd0, m_addr[i]} >= b && {8'd0, m_addr[i]} < b + l) m_vld[i] = 1'b0;
    check_all({rq, " R13 contents"});
  endtask

  task automatic load_near(input logic [63:0] op);
    logic [63:0] b, l, off;
    int st;
    st = ref_decode(op, 2'd3, gran, paw, b, l);
    for (int i = 0; i < N; i++) begin
      off = {$urandom, $urandom} % (3 * l);
      case (i % 4)
        0: off = 0;
        1: off = l;
        2: off = l - 64'h1000;
        default: ;
      endcase
      do_fill(i, 56'(b + off - l));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    logic [63:0] op;
    void'($urandom(32'd7331));
    for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !undef && !noop, "reset R11", {60'd0, req_ready, done, undef, noop}, 64'h8);
    rst_n = 1'b1;
    check_all("reset R13");

    // R10 lower levels
    gran = 2'd0; paw = 4'd5;
    op = {16'h0, 4'd1, 4'd0, 40'h100};
    load_near(op);
    for (int e = 0; e < 3; e++) do_req(op, 2'(e), "R10 level");
    // R3 reserved sizes
    do_req({16'h0, 4'd10, 4'd0, 40'h100}, 2'd3, "R3 size10");
    do_req({16'h0, 4'd15, 4'd0, 40'h100}, 2'd3, "R3 size15");
    // R4 reserved granule
    gran = 2'd3; do_req(op, 2'd3, "R4 gran3"); gran = 2'd0;
    // R7 misaligned 16KB at page 1
    do_req({16'h0, 4'd1, 4'd0, 40'h101}, 2'd3, "R7 misaligned");
    // R1 garbage high bits, R2 16KB
    do_req({16'hdead, 4'd1, 4'd0, 40'h100}, 2'd3, "R1 R2 high bits");
    // R6 size raised to 64KB, R5 low operand bits dropped
    gran = 2'd1;
    op = {16'h0, 4'd0, 4'd0, 40'h2003};
    load_near(op); do_req(op, 2'd3, "R5 R6 raise 64K");
    gran = 2'd2;
    op = {16'h0, 4'd0, 4'd0, 40'h4001};
    load_near(op); do_req(op, 2'd3, "R4 R5 16K");
    // R8 above 32-bit range
    gran = 2'd0; paw = 4'd0;
    op = {16'h0, 4'd0, 4'd0, 40'h100000};
    load_near(op); do_req(op, 2'd3, "R8 above");
    paw = 4'd15; op = {16'h0, 4'd0, 4'd0, 40'hFFFFFFFFF};
    load_near(op); do_req(op, 2'd3, "R8 default 48");
    // R9 extension bits
    paw = 4'd7; op = {16'h0, 4'd3, 4'h9, 40'h200};
    load_near(op); do_req(op, 2'd3, "R9 ext used");
    paw = 4'd6; op = {16'h0, 4'd3, 4'h9, 40'h200};
    load_near(op); do_req(op, 2'd3, "R9 ext ignored");

    // R12 fill stalled during walk
    paw = 4'd5; gran = 2'd0;
    op = {16'h0, 4'd2, 4'd0, 40'h400};
    load_near(op);
    @(negedge clk); req_valid = 1'b1; req_op = op; req_el = 2'd3;
    @(negedge clk); req_valid = 1'b0;
    fill_valid = 1'b1; fill_idx = IW'(5); fill_addr = 56'h400000;
    #1 chk(!fill_ready, "R12 stall", {63'd0, fill_ready}, 64'd0);
    while (!done) @(negedge clk);
    @(negedge clk); fill_valid = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_addr[i] >= 56'h400000 && m_addr[i] < 56'h410000) m_vld[i] = 1'b0;
    m_vld[5] = 1'b1; m_addr[5] = 56'h400000;
    check_all("R12 fill survives");

    // random mix
    for (int k = 0; k < 250; k++) begin
      logic [63:0] b, l;
      int s;
      gran = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      paw  = 4'($urandom % 10);
      op   = {$urandom, $urandom};
      op[47:44] = 4'($urandom % 12);
      s = ref_decode(op, 2'd3, gran, paw, b, l);
      if ($urandom % 4 != 0) op[39:0] = op[39:0] & ~((l >> 12) - 1);
      if ($urandom % 3 != 0) op[39:0] = op[39:0] & 40'h00FFFFFFF;
      load_near(op);
      do_req(op, ($urandom % 10 == 0) ? 2'($urandom % 3) : 2'd3, "R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule